// File: doc/BRIEF.md
# USB OUT Endpoint Transfer Tracker

This block holds the transfer bookkeeping for one OUT endpoint of a USB device controller. Before an OUT transfer, software loads a byte budget and a packet budget through a small register bus and then sets an enable bit. From that point the hardware owns the counts. Each time the packet engine pushes a received packet into the receive FIFO, the packet budget drops by one and the data PID of that packet is recorded. Each time the drain path moves a packet out of the FIFO into system memory, the byte budget drops by that packet's length.

When a drain leaves the byte budget at zero, the block sets a sticky completion flag, drives the interrupt output and clears the enable bit, which hands the counts back to software. Software can make the flag fire after every packet by loading one max-packet size as the byte budget. The flag is cleared by writing 1 to it.

Top module: `usb_out_xfer_track`

## Requirements
- R1: Address 0 reads the transfer word: byte count in bits 18:0, packet count in bits 28:19, received PID in bits 30:29, and bit 31 always 0. Address 1 reads the control word: bit 0 is the enable flag, bit 1 is the completion flag, and the other bits are 0.
- R2: After reset, both counts, the PID field, the enable flag and the completion flag are all zero, so both read words are 0.
- R3: A push strobe while enabled lowers the packet count by one on the next clock edge, and a count already at zero stays at zero.
- R4: A drain strobe while enabled lowers the byte count by `drain_bytes` on the next clock edge; when `drain_bytes` is at least the remaining count, the count becomes zero.
- R5: A push strobe while enabled stores `push_pid` in the PID field (00 = DATA0, 01 = DATA2, 10 = DATA1, 11 = MDATA). Bus writes never change the PID field.
- R6: A bus write to address 0 loads both counts from the write data while the endpoint is disabled and has no effect while it is enabled.
- R7: A drain while enabled that leaves the byte count at zero sets the completion flag, raises `xfer_irq` and clears the enable flag, all on the same clock edge.
- R8: The completion flag stays set until a write to address 1 with bit 1 set. A write with bit 1 clear leaves it unchanged. If completion and a clearing write happen in the same cycle, the flag ends up set.
- R9: A push and a drain in the same cycle are both applied, each to its own counter.
- R10: Push and drain strobes while the endpoint is disabled change neither count nor the PID field.
- R11: A write to address 1 sets or clears the enable flag from bit 0, unless a completion in the same cycle clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register address: 0 transfer word, 1 control word |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| push_vld | input | 1 | A packet was written into the receive FIFO |
| push_pid | input | 2 | Data PID code of the pushed packet |
| drain_vld | input | 1 | A packet was moved from the FIFO to memory |
| drain_bytes | input | 11 | Byte length of the drained packet |
| ep_en | output | 1 | Endpoint enable flag |
| xfer_irq | output | 1 | Completion interrupt, equal to the sticky flag |

## Verification
On every cycle, the in-line assertions check these rules: neither count rises while the endpoint is enabled, the counts and the PID field hold when no event or load reaches them, the completion flag survives until it is cleared by a write, a rising interrupt always comes with a zero byte count and a cleared enable, and the reserved bit reads zero. Only the bench's scenarios can show the exact arithmetic. This includes the saturation on an oversized drain, the PID code captured from each push, writes being dropped while enabled, both events being applied in the same cycle, and the completion winning over a clearing write in the same cycle. The bench checks these by comparing both read words and both outputs against a cycle model after every clock.

// File: rtl/oxt_pkg.sv
package oxt_pkg;
  parameter int BYTE_W  = 19;
  parameter int PKT_W   = 10;
  parameter int PID_W   = 2;
  parameter int DRAIN_W = 11;
  parameter int DATA_W  = 32;
  parameter int ADDR_W  = 1;

  localparam int PKT_LSB = BYTE_W;
  localparam int PID_LSB = BYTE_W + PKT_W;
  localparam int USED_W  = BYTE_W + PKT_W + PID_W;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_DONE_BIT = 1;

  typedef enum logic [PID_W-1:0] {
    PID_DATA0 = 2'b00,
    PID_DATA2 = 2'b01,
    PID_DATA1 = 2'b10,
    PID_MDATA = 2'b11
  } rx_pid_e;
endpackage

// File: rtl/oxt_byte_ctr.sv
module oxt_byte_ctr #(
  parameter int BYTE_W  = 19,
  parameter int DRAIN_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              drain_vld,
  input  logic [DRAIN_W-1:0] drain_bytes,
  output logic [BYTE_W-1:0] cnt,
  output logic              hit_zero
);
  localparam int PAD_W = BYTE_W - DRAIN_W;

  logic [BYTE_W-1:0] drain_ext;
  logic [BYTE_W-1:0] cnt_nxt;
  logic              cnt_en;
  logic              apply;
  logic              exhaust;

  assign drain_ext = {{PAD_W{1'b0}}, drain_bytes};
  assign apply     = active & drain_vld;
  assign exhaust   = (drain_ext >= cnt);
  assign hit_zero  = apply & exhaust;

  always_comb begin
    cnt_en  = 1'b0;
    cnt_nxt = cnt;
    if (apply) begin
      cnt_en  = 1'b1;
      cnt_nxt = exhaust ? '0 : (cnt - drain_ext);
    end else if (load && !active) begin
      cnt_en  = 1'b1;
      cnt_nxt = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end

  a_r4_bytes_never_rise: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (cnt <= $past(cnt)));
  a_r6_bytes_hold_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !drain_vld) |=> $stable(cnt));
  a_r10_bytes_idle_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !load) |=> $stable(cnt));
endmodule

// File: rtl/oxt_pkt_ctr.sv
module oxt_pkt_ctr #(
  parameter int PKT_W = 10,
  parameter int PID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             load,
  input  logic [PKT_W-1:0] load_val,
  input  logic             push_vld,
  input  logic [PID_W-1:0] push_pid,
  output logic [PKT_W-1:0] cnt,
  output logic [PID_W-1:0] pid
);
  logic             apply;
  logic             cnt_en;
  logic [PKT_W-1:0] cnt_nxt;

  assign apply = active & push_vld;

  always_comb begin
    cnt_en  = 1'b0;
    cnt_nxt = cnt;
    if (apply) begin
      cnt_en  = 1'b1;
      cnt_nxt = (cnt == '0) ? '0 : (cnt - 1'b1);
    end else if (load && !active) begin
      cnt_en  = 1'b1;
      cnt_nxt = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pid <= '0;
    else if (apply) pid <= push_pid;
  end

  a_r3_pkts_never_rise: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (cnt <= $past(cnt)));
  a_r6_pkts_hold_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !push_vld) |=> $stable(cnt));
  a_r5_pid_hold_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    !(active && push_vld) |=> $stable(pid));
endmodule

// File: rtl/oxt_ctl.sv
module oxt_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctl,
  input  logic wr_en_bit,
  input  logic wr_done_bit,
  input  logic hit_zero,
  output logic en,
  output logic done
);
  logic en_nxt;
  logic done_nxt;

  always_comb begin
    en_nxt = en;
    if (hit_zero)    en_nxt = 1'b0;
    else if (wr_ctl) en_nxt = wr_en_bit;
  end

  always_comb begin
    done_nxt = done;
    if (hit_zero)                  done_nxt = 1'b1;
    else if (wr_ctl && wr_done_bit) done_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      done <= 1'b0;
    end else begin
      en   <= en_nxt;
      done <= done_nxt;
    end
  end

  a_r7_done_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hit_zero |=> (done && !en));
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(wr_ctl && wr_done_bit)) |=> done);
endmodule

// File: rtl/usb_out_xfer_track.sv
module usb_out_xfer_track
  import oxt_pkg::*;
#(
  parameter int P_BYTE_W  = BYTE_W,
  parameter int P_PKT_W   = PKT_W,
  parameter int P_DRAIN_W = DRAIN_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 push_vld,
  input  logic [PID_W-1:0]     push_pid,
  input  logic                 drain_vld,
  input  logic [P_DRAIN_W-1:0] drain_bytes,
  output logic                 ep_en,
  output logic                 xfer_irq
);
  localparam logic [ADDR_W-1:0] ADR_XFER = '0;
  localparam int P_PKT_LSB = P_BYTE_W;
  localparam int P_PID_LSB = P_BYTE_W + P_PKT_W;
  localparam int P_USED_W  = P_BYTE_W + P_PKT_W + PID_W;

  logic                wr_xfer;
  logic                wr_ctl;
  logic [P_BYTE_W-1:0] byte_cnt;
  logic [P_PKT_W-1:0]  pkt_cnt;
  logic [PID_W-1:0]    rx_pid;
  logic                hit_zero;
  logic                done;
  logic [DATA_W-1:0]   word_xfer;
  logic [DATA_W-1:0]   word_ctl;
  logic                unused_wdata;

  assign wr_xfer      = bus_wr_en && (bus_addr == ADR_XFER);
  assign wr_ctl       = bus_wr_en && (bus_addr != ADR_XFER);
  assign unused_wdata = ^bus_wdata[DATA_W-1:P_PID_LSB];

  oxt_byte_ctr #(.BYTE_W(P_BYTE_W), .DRAIN_W(P_DRAIN_W)) u_bytes (
    .clk(clk), .rst_n(rst_n), .active(ep_en), .load(wr_xfer),
    .load_val(bus_wdata[P_BYTE_W-1:0]), .drain_vld(drain_vld),
    .drain_bytes(drain_bytes), .cnt(byte_cnt), .hit_zero(hit_zero)
  );

  oxt_pkt_ctr #(.PKT_W(P_PKT_W), .PID_W(PID_W)) u_pkts (
    .clk(clk), .rst_n(rst_n), .active(ep_en), .load(wr_xfer),
    .load_val(bus_wdata[P_PID_LSB-1:P_PKT_LSB]), .push_vld(push_vld),
    .push_pid(push_pid), .cnt(pkt_cnt), .pid(rx_pid)
  );

  oxt_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl),
    .wr_en_bit(bus_wdata[CTL_EN_BIT]), .wr_done_bit(bus_wdata[CTL_DONE_BIT]),
    .hit_zero(hit_zero), .en(ep_en), .done(done)
  );

  assign xfer_irq = done;

  always_comb begin
    word_xfer = '0;
    word_xfer[P_BYTE_W-1:0]          = byte_cnt;
    word_xfer[P_PID_LSB-1:P_PKT_LSB] = pkt_cnt;
    word_xfer[P_USED_W-1:P_PID_LSB]  = rx_pid;
    word_ctl = '0;
    word_ctl[CTL_EN_BIT]   = ep_en;
    word_ctl[CTL_DONE_BIT] = done;
  end

  assign bus_rdata = (bus_addr == ADR_XFER) ? word_xfer : word_ctl;

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADR_XFER) |-> (bus_rdata[DATA_W-1] == 1'b0));
  a_r7_irq_with_zero_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_irq) |-> (byte_cnt == '0 && !ep_en));
endmodule

// File: tb/tb_usb_out_xfer_track.sv
`timescale 1ns/1ps
module tb_usb_out_xfer_track;
  logic        clk;
  logic        rst_n;
  logic        bus_wr_en;
  logic [0:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        push_vld;
  logic [1:0]  push_pid;
  logic        drain_vld;
  logic [10:0] drain_bytes;
  logic        ep_en;
  logic        xfer_irq;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  logic [18:0] m_bytes;
  logic [9:0]  m_pkts;
  logic [1:0]  m_pid;
  logic        m_en;
  logic        m_done;

  usb_out_xfer_track dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .push_vld(push_vld),
    .push_pid(push_pid), .drain_vld(drain_vld), .drain_bytes(drain_bytes),
    .ep_en(ep_en), .xfer_irq(xfer_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] xfer_word(input logic [1:0] p, input logic [9:0] k,
                                            input logic [18:0] b);
    return {1'b0, p, k, b};
  endfunction

  function automatic logic [31:0] mk_load(input int k, input int b);
    logic [31:0] w;
    w = 32'hE000_0000;
    w[28:19] = k[9:0];
    w[18:0]  = b[18:0];
    return w;
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic check_state(input string tag);
    logic [31:0] exp0, exp1;
    exp0 = xfer_word(m_pid, m_pkts, m_bytes);
    exp1 = {30'd0, m_done, m_en};
    bus_addr = 1'b0; #1;
    checks++;
    if (bus_rdata !== exp0) begin
      errors++;
      $display("FAIL %s transfer word actual %h expected %h", tag, bus_rdata, exp0);
    end
    bus_addr = 1'b1; #1;
    checks++;
    if (bus_rdata !== exp1 || ep_en !== m_en || xfer_irq !== m_done) begin
      errors++;
      $display("FAIL %s control actual %h en %b irq %b expected %h en %b irq %b",
               tag, bus_rdata, ep_en, xfer_irq, exp1, m_en, m_done);
    end
  endtask

  task automatic idle_inputs();
    bus_wr_en = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
    push_vld = 1'b0; push_pid = '0; drain_vld = 1'b0; drain_bytes = '0;
  endtask

  task automatic cyc(input bit wr, input bit a, input logic [31:0] wd,
                     input bit ps, input logic [1:0] pid,
                     input bit dr, input int nb, input string tag);
    logic [18:0] nbytes;
    logic [9:0]  npkts;
    logic [1:0]  npid;
    logic        nen, ndone, hz;
    bus_wr_en = wr; bus_addr = a; bus_wdata = wd;
    push_vld = ps; push_pid = pid; drain_vld = dr; drain_bytes = nb[10:0];
    hz = m_en && dr && (nb >= int'(m_bytes));
    nbytes = m_bytes; npkts = m_pkts; npid = m_pid;
    if (m_en && dr) nbytes = hz ? 19'd0 : m_bytes - 19'(nb);
    else if (wr && !a && !m_en) nbytes = wd[18:0];
    if (m_en && ps) begin
      npkts = (m_pkts == 0) ? 10'd0 : m_pkts - 10'd1;
      npid  = pid;
    end else if (wr && !a && !m_en) npkts = wd[28:19];
    nen   = hz ? 1'b0 : ((wr && a) ? wd[0] : m_en);
    ndone = hz ? 1'b1 : ((wr && a && wd[1]) ? 1'b0 : m_done);
    @(posedge clk);
    #1;
    idle_inputs();
    m_bytes = nbytes; m_pkts = npkts; m_pid = npid; m_en = nen; m_done = ndone;
    check_state(tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed_set;
    seed_set = $urandom(32'h5EED_0417);
    idle_inputs();
    rst_n = 1'b0;
    m_bytes = '0; m_pkts = '0; m_pid = '0; m_en = 1'b0; m_done = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_state("R2 reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R2 after release");

    cyc(1, 0, mk_load(3, 200), 0, 0, 0, 0, "R1 R5 R6 load while disabled");
    cyc(0, 0, 0, 1, 2'b11, 0, 0, "R10 push disabled");
    cyc(0, 0, 0, 0, 0, 1, 50, "R10 drain disabled");
    cyc(1, 1, 32'h1, 0, 0, 0, 0, "R11 R1 enable");
    cyc(1, 0, mk_load(9, 9), 0, 0, 0, 0, "R6 write ignored enabled");
    cyc(0, 0, 0, 1, 2'b01, 0, 0, "R3 R5 push DATA2");
    cyc(0, 0, 0, 1, 2'b11, 1, 64, "R9 push and drain together");
    cyc(0, 0, 0, 0, 0, 1, 64, "R4 drain");
    cyc(0, 0, 0, 1, 2'b10, 0, 0, "R3 R5 push DATA1");
    cyc(0, 0, 0, 1, 2'b00, 0, 0, "R3 saturate at zero");
    cyc(0, 0, 0, 0, 0, 1, 500, "R4 R7 oversized drain completes");
    cyc(1, 1, 32'h0, 0, 0, 0, 0, "R8 sticky on write 0");
    cyc(1, 0, mk_load(1, 64), 0, 0, 0, 0, "R6 reload");
    cyc(1, 1, 32'h1, 0, 0, 0, 0, "R11 enable with flag set");
    cyc(1, 1, 32'h3, 0, 0, 1, 64, "R8 R7 completion beats clear");
    cyc(1, 1, 32'h2, 0, 0, 0, 0, "R8 write one clears");
    cyc(1, 0, mk_load(4, 100), 0, 0, 0, 0, "R6 reload");
    cyc(1, 1, 32'h1, 0, 0, 0, 0, "R11 enable");
    cyc(0, 0, 0, 0, 0, 1, 100, "R7 exact drain completes");
    cyc(1, 1, 32'h3, 0, 0, 0, 0, "R11 R8 enable and clear");
    cyc(1, 1, 32'h0, 0, 0, 0, 0, "R11 software disable");
    cyc(0, 0, 0, 1, 2'b01, 1, 1, "R10 events after disable");

    for (int i = 0; i < 3000; i++) begin
      bit          wr, a, ps, dr;
      logic [31:0] wd;
      int          nb;
      wr = ($urandom % 6) == 0;
      a  = $urandom % 2;
      wd = $urandom;
      if (!a) wd[18:0] = 19'($urandom % 300);
      else if (($urandom % 4) != 0) wd[0] = 1'b1;
      ps = $urandom % 2;
      dr = $urandom % 2;
      nb = $urandom % 80;
      cyc(wr, a, wd, ps, 2'($urandom), dr, nb, "R3 R4 R9 random");
    end
    finish_run();
  end
endmodule